// File: doc/BRIEF.md
# Multi-Word Mailbox Message Sender

This block pushes one message of any byte length into a group of `NUM_WIN` adjacent mailbox channel windows, each one data word wide. The windows are written through set strobes: a write ORs its data into the window's status. The topmost window of the group is the only one whose write raises the receiver's interrupt. The others are masked at the receiver. The sender therefore has to make sure that every burst of writes ends on the topmost window and that the value written there is never zero.

A message is accepted with a start pulse and a byte count. Its words then arrive in message order on a valid/ready stream. The sender splits the message into rounds of at most `NUM_WIN` words. It collects each round into a small word store, then writes that round from the lowest window it needs up to the topmost window. The first word of the round goes to the topmost window, the second word to the window just below it, and so on down. A partial trailing word has its unused high bytes cleared.

Before each round is written, the sender waits until the receiver reports the topmost window as cleared. If the word headed for the topmost window is zero, the sender drops the message and reports an error instead of writing that round. Busy, done and error flags report progress. Reassembly at the receiver is not part of the block.

Top module: `mbx_msg_sender`

## Requirements
- R1: A start with a length of zero produces a one-cycle `done` pulse in the cycle after the start is accepted. It issues no window write, takes no word from the stream and never raises `busy`.
- R2: Each round carries min(remaining bytes, `NUM_WIN`×4) bytes in ceil(round bytes/4) words. The number of window writes for a whole message is the sum of these word counts over all rounds.
- R3: Word m of a round (m = 0 for the round's first word) is written to window `NUM_WIN`-1-m. When a round has k words, windows below `NUM_WIN`-k are not written.
- R4: A round's writes come on consecutive cycles, one per cycle, with window indices rising by one. The last write of every round targets window `NUM_WIN`-1.
- R5: When a round's byte count is not a multiple of 4, its last word keeps only its low (round bytes mod 4) bytes. Bits [7:0] are byte 0, and the higher bytes are forced to zero.
- R6: No write of a round is issued unless `trig_idle` (topmost window status equal to zero) has been high since the previous write to the topmost window.
- R7: If a round's word for window `NUM_WIN`-1, after masking, is zero, that round issues no write, `err` pulses for one cycle and the block returns to idle without `done`. When this happens in the first round, nothing is written at all.
- R8: `busy` is high from the cycle after a nonzero-length start is accepted until the cycle of the final write. `done` pulses for exactly one cycle right after the final write, and `busy` is low while `done` is high.
- R9: `word_ready` is high only while a round is being collected and never together with `win_set`. A finished message takes exactly ceil(length/4) words from the stream.
- R10: During and right after reset, `busy`, `done`, `err`, `win_set` and `word_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| msg_start | input | 1 | Start pulse, taken only when idle |
| msg_len | input | LEN_W | Message length in bytes, sampled with the start |
| word_valid | input | 1 | Stream word valid |
| word_data | input | DATA_W | Stream word, in message order |
| word_ready | output | 1 | Stream word accepted when high together with `word_valid` |
| trig_idle | input | 1 | High when the topmost window's status reads zero |
| win_set | output | 1 | Window set strobe |
| win_sel | output | WIN_W | Index of the window being set |
| win_wdata | output | DATA_W | Data ORed into the selected window |
| busy | output | 1 | Message in progress |
| done | output | 1 | One-cycle pulse after the last write |
| err | output | 1 | One-cycle pulse when a round is refused for a zero trigger word |

## Verification
Suppose the remaining-byte count or the round word count goes wrong. The port trace shows it within that round: the round starts at the wrong window, writes the wrong number of words, or its last write misses window `NUM_WIN`-1. A wrong gather pointer or a wrong read slot puts message words on the wrong windows, and the mismatch appears in the data of the very next write. A skipped wait on `trig_idle` shows up at the first write of the following round, which lands while the topmost window is still set. A bad end-of-message decision shows up one cycle after the final write, either as a missing or early `done` pulse or as words still being taken from the stream.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_HOLD = 2'd2,
    ST_SEND = 2'd3
  } mbx_state_e;

endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/mbx_round_plan.sv
module mbx_round_plan #(
  parameter int NUM_WIN = 4,
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 12
) (
  input  logic [LEN_W-1:0]                 remain,
  output logic [LEN_W-1:0]                 rnd_bytes,
  output logic [$clog2(NUM_WIN+1)-1:0]     rnd_words,
  output logic [DATA_W/8-1:0]              tail_keep
);

  localparam int BPW     = DATA_W / 8;
  localparam int BPW_LG  = $clog2(BPW);
  localparam int CNT_W   = $clog2(NUM_WIN + 1);
  localparam int RND_CAP = NUM_WIN * BPW;

  logic             full_round;
  logic [BPW_LG-1:0] tail_bytes;

  assign full_round = (remain >= LEN_W'(RND_CAP));
  assign rnd_bytes  = full_round ? LEN_W'(RND_CAP) : remain;
  assign rnd_words  = full_round ? CNT_W'(NUM_WIN)
                                 : CNT_W'((remain + LEN_W'(BPW - 1)) >> BPW_LG);
  assign tail_bytes = rnd_bytes[BPW_LG-1:0];

  for (genvar b = 0; b < BPW; b++) begin : g_keep
    assign tail_keep[b] = (tail_bytes == '0) || (BPW_LG'(b) < tail_bytes);
  end

endmodule

// File: rtl/mbx_word_buf.sv
module mbx_word_buf #(
  parameter int NUM_WIN = 4,
  parameter int DATA_W  = 32
) (
  input  logic                                     clk,
  input  logic                                     wr_en,
  input  logic [((NUM_WIN > 1) ? $clog2(NUM_WIN) : 1)-1:0] wr_slot,
  input  logic [DATA_W-1:0]                        wr_data,
  input  logic [DATA_W/8-1:0]                      wr_keep,
  input  logic [((NUM_WIN > 1) ? $clog2(NUM_WIN) : 1)-1:0] rd_slot,
  output logic [DATA_W-1:0]                        rd_data,
  output logic [DATA_W-1:0]                        head_word
);

  localparam int BPW   = DATA_W / 8;
  localparam int WIN_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  logic [DATA_W-1:0] kept_data;
  logic [DATA_W-1:0] slot_arr [NUM_WIN];

  for (genvar b = 0; b < BPW; b++) begin : g_byte
    assign kept_data[b*8 +: 8] = wr_keep[b] ? wr_data[b*8 +: 8] : 8'h00;
  end

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_slot
    logic             slot_en;
    logic [DATA_W-1:0] slot_q;

    assign slot_en = wr_en && (wr_slot == WIN_W'(i));

    always_ff @(posedge clk) begin
      if (slot_en) begin
        slot_q <= kept_data;
      end
    end

    assign slot_arr[i] = slot_q;
  end

  assign rd_data   = slot_arr[rd_slot];
  assign head_word = slot_arr[0];

endmodule

// File: rtl/mbx_tx_ctrl.sv
module mbx_tx_ctrl
  import mbx_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 12
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     start,
  input  logic [LEN_W-1:0]                         len,
  input  logic                                     word_valid,
  input  logic                                     trig_idle,
  input  logic [LEN_W-1:0]                         rnd_bytes,
  input  logic [$clog2(NUM_WIN+1)-1:0]             rnd_words,
  input  logic [DATA_W/8-1:0]                      tail_keep,
  input  logic [DATA_W-1:0]                        head_word,
  output logic [LEN_W-1:0]                         remain,
  output logic                                     word_ready,
  output logic                                     buf_wr,
  output logic [((NUM_WIN > 1) ? $clog2(NUM_WIN) : 1)-1:0] buf_wr_slot,
  output logic [DATA_W/8-1:0]                      buf_keep,
  output logic [((NUM_WIN > 1) ? $clog2(NUM_WIN) : 1)-1:0] buf_rd_slot,
  output logic                                     win_set,
  output logic [((NUM_WIN > 1) ? $clog2(NUM_WIN) : 1)-1:0] win_sel,
  output logic                                     busy,
  output logic                                     done,
  output logic                                     err
);

  localparam int BPW   = DATA_W / 8;
  localparam int CNT_W = $clog2(NUM_WIN + 1);
  localparam int WIN_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  mbx_state_e       st_q, st_n;
  logic [LEN_W-1:0] rem_q, rem_n;
  logic             rem_en;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             done_q, done_n;
  logic             err_q, err_n;
  logic             last_word;
  logic             take_word;

  assign last_word = (cnt_q == (rnd_words - CNT_W'(1)));
  assign take_word = (st_q == ST_FILL) && word_valid;

  // next-state logic
  always_comb begin
    st_n   = st_q;
    rem_n  = rem_q;
    rem_en = 1'b0;
    cnt_n  = cnt_q;
    done_n = 1'b0;
    err_n  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (len == '0) begin
            done_n = 1'b1;
          end else begin
            rem_n  = len;
            rem_en = 1'b1;
            cnt_n  = '0;
            st_n   = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        if (word_valid) begin
          if (last_word) begin
            cnt_n = '0;
            st_n  = ST_HOLD;
          end else begin
            cnt_n = cnt_q + CNT_W'(1);
          end
        end
      end
      ST_HOLD: begin
        if (head_word == '0) begin
          err_n = 1'b1;
          st_n  = ST_IDLE;
        end else if (trig_idle) begin
          st_n = ST_SEND;
        end
      end
      ST_SEND: begin
        if (last_word) begin
          cnt_n  = '0;
          rem_n  = rem_q - rnd_bytes;
          rem_en = 1'b1;
          if (rem_q == rnd_bytes) begin
            done_n = 1'b1;
            st_n   = ST_IDLE;
          end else begin
            st_n = ST_FILL;
          end
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
      err_q  <= err_n;
    end
  end

  // remaining byte count, clock-enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (rem_en) begin
      rem_q <= rem_n;
    end
  end

  assign remain      = rem_q;
  assign word_ready  = (st_q == ST_FILL);
  assign buf_wr      = take_word;
  assign buf_wr_slot = WIN_W'(cnt_q);
  assign buf_keep    = last_word ? tail_keep : {BPW{1'b1}};
  assign buf_rd_slot = WIN_W'(rnd_words - CNT_W'(1) - cnt_q);
  assign win_set     = (st_q == ST_SEND);
  assign win_sel     = WIN_W'(CNT_W'(NUM_WIN) - rnd_words + cnt_q);
  assign busy        = (st_q != ST_IDLE);
  assign done        = done_q;
  assign err         = err_q;

endmodule

// File: rtl/mbx_msg_sender.sv
module mbx_msg_sender #(
  parameter int NUM_WIN = 4,
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 12
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     msg_start,
  input  logic [LEN_W-1:0]                         msg_len,
  input  logic                                     word_valid,
  input  logic [DATA_W-1:0]                        word_data,
  output logic                                     word_ready,
  input  logic                                     trig_idle,
  output logic                                     win_set,
  output logic [((NUM_WIN > 1) ? $clog2(NUM_WIN) : 1)-1:0] win_sel,
  output logic [DATA_W-1:0]                        win_wdata,
  output logic                                     busy,
  output logic                                     done,
  output logic                                     err
);

  localparam int BPW   = DATA_W / 8;
  localparam int CNT_W = $clog2(NUM_WIN + 1);
  localparam int WIN_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  logic              rst_core_n;
  logic [LEN_W-1:0]  remain;
  logic [LEN_W-1:0]  rnd_bytes;
  logic [CNT_W-1:0]  rnd_words;
  logic [BPW-1:0]    tail_keep;
  logic [BPW-1:0]    buf_keep;
  logic              buf_wr;
  logic [WIN_W-1:0]  buf_wr_slot;
  logic [WIN_W-1:0]  buf_rd_slot;
  logic [DATA_W-1:0] head_word;

  mbx_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  mbx_round_plan #(
    .NUM_WIN (NUM_WIN),
    .DATA_W  (DATA_W),
    .LEN_W   (LEN_W)
  ) u_plan (
    .remain    (remain),
    .rnd_bytes (rnd_bytes),
    .rnd_words (rnd_words),
    .tail_keep (tail_keep)
  );

  mbx_word_buf #(
    .NUM_WIN (NUM_WIN),
    .DATA_W  (DATA_W)
  ) u_buf (
    .clk       (clk),
    .wr_en     (buf_wr),
    .wr_slot   (buf_wr_slot),
    .wr_data   (word_data),
    .wr_keep   (buf_keep),
    .rd_slot   (buf_rd_slot),
    .rd_data   (win_wdata),
    .head_word (head_word)
  );

  mbx_tx_ctrl #(
    .NUM_WIN (NUM_WIN),
    .DATA_W  (DATA_W),
    .LEN_W   (LEN_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .start       (msg_start),
    .len         (msg_len),
    .word_valid  (word_valid),
    .trig_idle   (trig_idle),
    .rnd_bytes   (rnd_bytes),
    .rnd_words   (rnd_words),
    .tail_keep   (tail_keep),
    .head_word   (head_word),
    .remain      (remain),
    .word_ready  (word_ready),
    .buf_wr      (buf_wr),
    .buf_wr_slot (buf_wr_slot),
    .buf_keep    (buf_keep),
    .buf_rd_slot (buf_rd_slot),
    .win_set     (win_set),
    .win_sel     (win_sel),
    .busy        (busy),
    .done        (done),
    .err         (err)
  );

endmodule

// File: rtl/mbx_msg_sender_chk.sv
module mbx_msg_sender_chk #(
  parameter int NUM_WIN = 4,
  parameter int DATA_W  = 32
) (
  input logic                                     clk,
  input logic                                     rst_n,
  input logic                                     word_ready,
  input logic                                     win_set,
  input logic [((NUM_WIN > 1) ? $clog2(NUM_WIN) : 1)-1:0] win_sel,
  input logic [DATA_W-1:0]                        win_wdata,
  input logic                                     busy,
  input logic                                     done,
  input logic                                     err
);

  localparam int WIN_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam logic [WIN_W-1:0] TOP_WIN = WIN_W'(NUM_WIN - 1);

  AST_WR_RISING_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (win_set && $past(win_set)) |-> (win_sel == WIN_W'($past(win_sel) + 1'b1))); // R4

  AST_BURST_ENDS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(win_set) && !win_set) |-> ($past(win_sel) == TOP_WIN)); // R4

  AST_TOP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (win_set && (win_sel == TOP_WIN)) |-> (win_wdata != '0)); // R7

  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !win_set && !done)); // R7

  AST_SET_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    win_set |-> busy); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8

  AST_READY_NOT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_ready && win_set)); // R9

endmodule

bind mbx_msg_sender mbx_msg_sender_chk #(
  .NUM_WIN (NUM_WIN),
  .DATA_W  (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .word_ready (word_ready),
  .win_set    (win_set),
  .win_sel    (win_sel),
  .win_wdata  (win_wdata),
  .busy       (busy),
  .done       (done),
  .err        (err)
);

// File: tb/mbx_msg_sender_bench.sv
module mbx_msg_sender_bench;

  localparam int NW    = 4;
  localparam int LEN_W = 12;

  logic        clk;
  logic        rst_n;
  logic        msg_start;
  logic [LEN_W-1:0] msg_len;
  logic        word_valid;
  logic [31:0] word_data;
  logic        word_ready;
  logic        trig_idle;
  logic        win_set;
  logic [1:0]  win_sel;
  logic [31:0] win_wdata;
  logic        busy;
  logic        done;
  logic        err;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [31:0] msg [0:15];
  int          src_ptr = 0;
  int          stall = 0;
  int          rx_dly = 0;
  logic [31:0] trig_stat;
  int          hold_cnt;

  int          log_n = 0;
  int          log_idx [0:63];
  logic [31:0] log_dat [0:63];
  int          log_cyc [0:63];
  int          done_cnt = 0;
  int          err_cnt = 0;
  int          done_cyc = 0;
  int          start_cyc = 0;
  bit          busy_seen = 0;
  bit          prev_set = 0;

  int          exp_idx [0:63];
  logic [31:0] exp_dat [0:63];
  bit          exp_msk [0:63];

  mbx_msg_sender #(.NUM_WIN(NW), .DATA_W(32), .LEN_W(LEN_W)) u_mbx_msg_sender (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_start  (msg_start),
    .msg_len    (msg_len),
    .word_valid (word_valid),
    .word_data  (word_data),
    .word_ready (word_ready),
    .trig_idle  (trig_idle),
    .win_set    (win_set),
    .win_sel    (win_sel),
    .win_wdata  (win_wdata),
    .busy       (busy),
    .done       (done),
    .err        (err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] pat(input int j);
    return {8'(8'h81 + j), 8'(8'h42 + j), 8'(8'h23 + j), 8'(8'h14 + j)};
  endfunction

  function automatic logic [31:0] keep_low(input logic [31:0] w, input int t);
    if (t == 0) return w;
    return w & ((32'h1 << (8 * t)) - 32'h1);
  endfunction

  // watchdog and cycle count
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // receiver model of the topmost window and stream source pointer
  assign trig_idle = (trig_stat == 32'h0);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_stat <= 32'h0;
      hold_cnt  <= 0;
    end else if (win_set && (win_sel == 2'(NW - 1))) begin
      trig_stat <= trig_stat | win_wdata;
      hold_cnt  <= rx_dly;
    end else if (trig_stat != 32'h0) begin
      if (hold_cnt == 0) trig_stat <= 32'h0;
      else hold_cnt <= hold_cnt - 1;
    end
  end

  always @(posedge clk) begin
    if (word_valid && word_ready) src_ptr <= src_ptr + 1;
  end

  // input driver away from the active edge
  always @(negedge clk) begin
    word_valid <= (src_ptr < 16) && ((stall == 0) || ((cyc % 3) != 1));
    word_data  <= (src_ptr < 16) ? msg[src_ptr] : 32'h0;
  end

  // output monitor away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (win_set) begin
        if (log_n < 64) begin
          log_idx[log_n] = int'(win_sel);
          log_dat[log_n] = win_wdata;
          log_cyc[log_n] = cyc;
          log_n++;
        end
        if (!prev_set) check(trig_stat == 32'h0, "R6 round began with trigger window set", trig_stat, 0);
        check(busy == 1'b1, "R8 busy during write", busy, 1);
      end
      if (done) begin
        done_cnt++;
        done_cyc = cyc;
        check(busy == 1'b0, "R8 busy low with done", busy, 0);
      end
      if (err) begin
        err_cnt++;
        check(busy == 1'b0, "R7 busy low with err", busy, 0);
      end
      if (busy) busy_seen = 1;
      prev_set = win_set;
    end
  end

  task automatic run_msg(input int len, input int stl, input int dly, input int zidx, input logic [31:0] zval);
    int t, rem, j, k, rb, tail, exp_n, consumed;
    bit exp_err;
    logic [31:0] w [0:3];
    for (int m = 0; m < 16; m++) msg[m] = pat(m + len);
    if (zidx >= 0) msg[zidx] = zval;
    @(negedge clk);
    stall = stl;
    rx_dly = dly;
    log_n = 0;
    done_cnt = 0;
    err_cnt = 0;
    busy_seen = 0;
    src_ptr = 0;
    msg_len = LEN_W'(len);
    msg_start = 1'b1;
    start_cyc = cyc;
    @(negedge clk);
    msg_start = 1'b0;
    t = 0;
    while ((done_cnt + err_cnt) == 0 && t < 400) begin
      @(posedge clk);
      t++;
    end
    check(t < 400, "R8 message did not finish", t, 0);
    repeat (4) @(posedge clk);

    // expected trace from the requirements
    rem = len; j = 0; exp_n = 0; exp_err = 0; consumed = 0;
    while (rem > 0) begin
      rb = (rem < NW * 4) ? rem : NW * 4;
      k = (rb + 3) / 4;
      tail = rb % 4;
      for (int m = 0; m < k; m++) w[m] = (m == k - 1) ? keep_low(msg[j + m], tail) : msg[j + m];
      consumed += k;
      if (w[0] == 32'h0) begin
        exp_err = 1;
        break;
      end
      for (int c = 0; c < k; c++) begin
        exp_idx[exp_n] = NW - k + c;
        exp_dat[exp_n] = w[k - 1 - c];
        exp_msk[exp_n] = (tail != 0) && (c == 0);
        exp_n++;
      end
      rem -= rb;
      j += k;
    end

    check(log_n == exp_n, "R2 write count", log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      check(log_idx[i] == exp_idx[i], "R3 window index", log_idx[i], exp_idx[i]);
      if (exp_msk[i]) check(log_dat[i] == exp_dat[i], "R5 masked tail word", log_dat[i], exp_dat[i]);
      else check(log_dat[i] == exp_dat[i], "R3 word data", log_dat[i], exp_dat[i]);
      if (i > 0 && exp_idx[i] > exp_idx[i - 1])
        check(log_cyc[i] == log_cyc[i - 1] + 1, "R4 consecutive writes", log_cyc[i], log_cyc[i - 1] + 1);
    end
    check(err_cnt == int'(exp_err), "R7 err pulses", err_cnt, exp_err);
    check(done_cnt == int'(!exp_err), "R8 done pulses", done_cnt, !exp_err);
    check(src_ptr == consumed, "R9 words taken", src_ptr, consumed);
    if (len == 0) begin
      check(done_cyc == start_cyc + 1, "R1 zero length done timing", done_cyc, start_cyc + 1);
      check(busy_seen == 0, "R1 busy stayed low", busy_seen, 0);
    end else if (!exp_err && exp_n > 0 && log_n > 0) begin
      check(done_cyc == log_cyc[log_n - 1] + 1, "R8 done after final write", done_cyc, log_cyc[log_n - 1] + 1);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    msg_start = 1'b0;
    msg_len = '0;
    for (int m = 0; m < 16; m++) msg[m] = pat(m);
    repeat (3) @(negedge clk);
    check({busy, done, err, win_set, word_ready} == 5'b0, "R10 outputs in reset",
          {busy, done, err, win_set, word_ready}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({busy, done, err, win_set, word_ready} == 5'b0, "R10 outputs after reset",
          {busy, done, err, win_set, word_ready}, 0);

    // length sweep over every byte count up to four rounds
    for (int len = 0; len <= 64; len++) begin
      run_msg(len, 0, len % 4, -1, 32'h0);
      run_msg(len, 1, 5, -1, 32'h0);
    end

    // R7: zero trigger word in the first round, full and masked
    run_msg(8, 0, 1, 0, 32'h0);
    run_msg(3, 1, 1, 0, 32'hFF00_0000);
    // R7: refusal in a later round after round one went out
    run_msg(40, 0, 2, 4, 32'h0);
    run_msg(17, 1, 2, 4, 32'hFFFF_FF00);
    // R7 negative: zero in a non-trigger slot is sent normally
    run_msg(8, 0, 0, 1, 32'h0);
    run_msg(16, 1, 3, 3, 32'h0);
    // R6: long receiver delay between rounds
    run_msg(48, 0, 20, -1, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule